// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter with Slave Clock

This block sends one character per load on a serial data line. The character goes out as a low start bit, then 8 or 9 data bits with the least significant bit first, then one or more high stop bits. Bit timing comes from a one-cycle oversampling tick input. Every bit lasts sixteen ticks.

While the data bits are on the line, the block also drives a clock output. An attached slave can shift on one clock edge and sample on the other. The idle level and the active edge of that clock can be set. An option turns off the clock pulse of the final data bit. The slave's reply line is sampled in the middle of each data bit. When the stop bits have ended, the reply word is presented with a one-cycle strobe.

A parallel load port accepts a new word only while the block is idle. The four configuration inputs are followed while the block is idle and frozen while a frame is in progress.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, `txd` is 1, `busy`, `rx_strobe` and `rx_word` are 0, and `sclk` is 0. While idle, `sclk` follows `cfg_cpol` two clocks after that input changes.
- R2: A frame holds the following bits in order, each lasting 16 `os_tick` pulses: one start bit at 0, then the data bits of `load_word` starting at bit 0, then `STOP_BITS` stop bits at 1. There are 9 data bits when `cfg_long` is 1 and 8 when it is 0. `txd` shows the bit position reached at a tick one clock after the edge that takes that tick.
- R3: `sclk` holds its idle level (equal to `cfg_cpol`) during the start bit, the stop bits and idle time.
- R4: Within a data bit whose pulse is emitted, `sclk` is at the non-idle level for ticks 8 to 15 when `cfg_cpha` is 0, and for ticks 0 to 7 when `cfg_cpha` is 1. Here ticks are counted 0 to 15 from the start of the bit.
- R5: When `cfg_last_pulse` is 0, no pulse is emitted during the last data bit (bit 8 in long mode, bit 7 otherwise). When it is 1, that pulse is emitted like the others.
- R6: `rxd` is sampled at the clock edge that takes tick 7 of each data bit, whether or not a pulse is emitted. The sample of data bit i is stored at bit i of the reply. In short mode, bit 8 of the reply is 0.
- R7: `rx_strobe` is 1 for exactly one clock, starting at the edge that takes the last tick of the last stop bit. `rx_word` holds the reply from that edge onward. `busy` falls at the same edge.
- R8: `busy` rises at the edge where `load_en` is sampled high while idle, and stays 1 for the whole frame. A `load_en` pulse while busy has no effect on the frame in progress and does not start a new one.
- R9: The configuration inputs are captured at the load edge. Changes to them during a frame do not alter `txd`, `sclk` or the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | One-cycle oversampling tick, 16 per bit |
| cfg_long | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: pulse in the second half of a bit, 1: pulse in the first half |
| cfg_last_pulse | input | 1 | 1: emit the clock pulse of the last data bit |
| load_en | input | 1 | Start a frame with `load_word` (taken only while idle) |
| load_word | input | LONG_W | Word to transmit |
| rxd | input | 1 | Reply data from the slave |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Clock for the slave |
| busy | output | 1 | Frame in progress |
| rx_word | output | LONG_W | Captured reply |
| rx_strobe | output | 1 | One-cycle reply valid pulse |

## Verification
`busy` changes at the load edge. `txd` and `sclk` change one clock after the edge that takes a tick, because both outputs are registered. `rx_strobe`, `rx_word` and the fall of `busy` appear at the edge that takes the final tick. The idle clock level follows `cfg_cpol` two clocks after the input changes.

The bench drives every input at the falling edge. It raises the tick for a single cycle and then leaves at least two rising edges before it samples the line outputs. It checks the strobe at the falling edge straight after the final tick, and checks that the strobe is low again one clock later. On `rxd` it presents the reply bit only in the cycle of the capture tick and random values at all other times. A sample taken at the wrong tick is therefore caught.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef struct packed {
    logic long_mode;
    logic cpol;
    logic cpha;
    logic last_pulse;
  } ssm_cfg_t;

  // Number of data bits for the selected word length.
  function automatic int word_bits(input logic long_mode, input int long_w);
    return long_mode ? long_w : long_w - 1;
  endfunction

  // Bit position idx (0 = start) lies inside the data field.
  function automatic logic in_data(input int idx, input int dlen);
    return (idx >= 1) && (idx <= dlen);
  endfunction

  // Non-idle clock level wanted at bit position idx, tick cnt.
  function automatic logic pulse_on(input int idx, input int cnt, input int dlen,
                                    input int os, input logic cpha,
                                    input logic last_pulse);
    logic live;
    live = in_data(idx, dlen) && !((idx == dlen) && !last_pulse);
    return live && (cpha ? (cnt < os / 2) : (cnt >= os / 2));
  endfunction

endpackage

// File: rtl/ssm_bit_timer.sv
module ssm_bit_timer #(
  parameter int OS_RATE = 16,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [IDX_W-1:0] dlen,
  output logic             active,
  output logic [IDX_W-1:0] bit_idx,
  output logic [CNT_W-1:0] phase,
  output logic             sample_evt,
  output logic             done_evt
);
  import ssm_pkg::*;

  logic bit_end;

  assign bit_end    = (phase == CNT_W'(OS_RATE - 1));
  assign sample_evt = active && tick && (phase == CNT_W'(OS_RATE / 2 - 1)) &&
                      in_data(int'(bit_idx), int'(dlen));
  assign done_evt   = active && tick && bit_end && (bit_idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_idx <= '0;
      phase   <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      bit_idx <= '0;
      phase   <= '0;
    end else if (active && tick) begin
      if (bit_end) begin
        phase <= '0;
        if (bit_idx == last_idx) active <= 1'b0;
        else bit_idx <= bit_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tick |=> $stable(phase) && $stable(bit_idx));

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bit_idx <= last_idx);

  // R8
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !active |=> active && (bit_idx == '0) && (phase == '0));

endmodule

// File: rtl/ssm_rx_capture.sv
module ssm_rx_capture #(
  parameter int LONG_W = 9,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample_evt,
  input  logic [IDX_W-1:0]  slot,
  input  logic              rxd,
  input  logic              done_evt,
  output logic [LONG_W-1:0] rx_word,
  output logic              rx_strobe
);

  logic [LONG_W-1:0] grab_q;
  logic [LONG_W-1:0] grab_d;

  always_comb begin
    grab_d = grab_q;
    for (int i = 0; i < LONG_W; i++) begin
      if (sample_evt && (slot == IDX_W'(i))) grab_d[i] = rxd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grab_q    <= '0;
      rx_word   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      grab_q    <= start ? '0 : grab_d;
      rx_strobe <= done_evt;
      if (done_evt) rx_word <= grab_d;
    end
  end

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  // R6
  grab_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt && !start |=> $stable(grab_q));

endmodule

// File: rtl/ssm_line_drive.sv
module ssm_line_drive #(
  parameter int OS_RATE = 16,
  parameter int CNT_W   = 4,
  parameter int IDX_W   = 4,
  parameter int LONG_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [CNT_W-1:0]  phase,
  input  logic [IDX_W-1:0]  dlen,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              last_pulse,
  input  logic [LONG_W-1:0] tx_word,
  output logic              txd,
  output logic              sclk
);
  import ssm_pkg::*;

  logic tx_next;
  logic pulse_next;

  always_comb begin
    tx_next = 1'b1;
    if (active) begin
      if (bit_idx == '0) begin
        tx_next = 1'b0;
      end else begin
        for (int i = 0; i < LONG_W; i++) begin
          if ((int'(bit_idx) == i + 1) && (i < int'(dlen))) tx_next = tx_word[i];
        end
      end
    end
  end

  assign pulse_next = active && pulse_on(int'(bit_idx), int'(phase), int'(dlen),
                                         OS_RATE, cpha, last_pulse);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd  <= 1'b1;
      sclk <= 1'b0;
    end else begin
      txd  <= tx_next;
      sclk <= cpol ^ pulse_next;
    end
  end

  // R3
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> sclk == $past(cpol));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) && ($past(bit_idx) == '0) |-> !txd);

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> txd);

endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master #(
  parameter int OS_RATE   = 16,
  parameter int LONG_W    = 9,
  parameter int STOP_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              cfg_long,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_last_pulse,
  input  logic              load_en,
  input  logic [LONG_W-1:0] load_word,
  input  logic              rxd,
  output logic              txd,
  output logic              sclk,
  output logic              busy,
  output logic [LONG_W-1:0] rx_word,
  output logic              rx_strobe
);
  import ssm_pkg::*;

  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(LONG_W + STOP_BITS + 2);

  ssm_cfg_t          cfg_q;
  logic [LONG_W-1:0] word_q;
  logic              active;
  logic              load_acc;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  phase;
  logic [IDX_W-1:0]  dlen;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  slot;
  logic              sample_evt;
  logic              done_evt;

  assign load_acc = load_en && !active;
  assign dlen     = IDX_W'(word_bits(cfg_q.long_mode, LONG_W));
  assign last_idx = IDX_W'(word_bits(cfg_q.long_mode, LONG_W) + STOP_BITS);
  assign slot     = bit_idx - 1'b1;
  assign busy     = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      word_q <= '0;
    end else begin
      if (!active) cfg_q <= '{long_mode: cfg_long, cpol: cfg_cpol,
                              cpha: cfg_cpha, last_pulse: cfg_last_pulse};
      if (load_acc) word_q <= load_word;
    end
  end

  ssm_bit_timer #(.OS_RATE(OS_RATE), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .start(load_acc),
    .last_idx(last_idx), .dlen(dlen), .active(active), .bit_idx(bit_idx),
    .phase(phase), .sample_evt(sample_evt), .done_evt(done_evt)
  );

  ssm_line_drive #(.OS_RATE(OS_RATE), .CNT_W(CNT_W), .IDX_W(IDX_W),
                   .LONG_W(LONG_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .active(active), .bit_idx(bit_idx),
    .phase(phase), .dlen(dlen), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha),
    .last_pulse(cfg_q.last_pulse), .tx_word(word_q), .txd(txd), .sclk(sclk)
  );

  ssm_rx_capture #(.LONG_W(LONG_W), .IDX_W(IDX_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .start(load_acc), .sample_evt(sample_evt),
    .slot(slot), .rxd(rxd), .done_evt(done_evt), .rx_word(rx_word),
    .rx_strobe(rx_strobe)
  );

  // R9
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> $stable(cfg_q) && $stable(word_q));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> !busy && $past(busy));

  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && load_en |=> $stable(word_q));

endmodule

// File: tb/test_sync_serial_master.sv
module test_sync_serial_master;
  localparam int OS = 16;
  localparam int LW = 9;
  localparam int SB = 1;

  logic          clk = 1'b0;
  logic          rst_n, os_tick, cfg_long, cfg_cpol, cfg_cpha, cfg_last_pulse;
  logic          load_en, rxd;
  logic [LW-1:0] load_word;
  logic          txd, sclk, busy, rx_strobe;
  logic [LW-1:0] rx_word;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  sync_serial_master #(.OS_RATE(OS), .LONG_W(LW), .STOP_BITS(SB)) i_sync_serial_master (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_long(cfg_long),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_last_pulse(cfg_last_pulse),
    .load_en(load_en), .load_word(load_word), .rxd(rxd), .txd(txd),
    .sclk(sclk), .busy(busy), .rx_word(rx_word), .rx_strobe(rx_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits(input bit lng);
    return lng ? LW : LW - 1;
  endfunction

  function automatic bit want_tx(input int k, input bit lng, input logic [LW-1:0] w);
    int b = k / OS;
    if (b == 0) return 1'b0;
    if (b <= nbits(lng)) return w[b-1];
    return 1'b1;
  endfunction

  function automatic bit want_clk(input int k, input bit lng, input bit pol,
                                  input bit pha, input bit lastp);
    int b = k / OS;
    int c = k % OS;
    int n = nbits(lng);
    bit hot;
    hot = (b >= 1) && (b <= n) && !(b == n && !lastp);
    if (hot) hot = pha ? (c < OS / 2) : (c >= OS / 2);
    return pol ^ hot;
  endfunction

  function automatic logic [LW-1:0] want_reply(input bit lng, input logic [LW-1:0] r);
    return lng ? r : {1'b0, r[LW-2:0]};
  endfunction

  task automatic run_frame(input bit lng, input bit pol, input bit pha, input bit lastp,
                           input logic [LW-1:0] word, input logic [LW-1:0] reply,
                           input bit noisy);
    int total = (1 + nbits(lng) + SB) * OS;
    @(negedge clk);
    cfg_long = lng; cfg_cpol = pol; cfg_cpha = pha; cfg_last_pulse = lastp;
    load_word = word; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    chk(busy == 1'b1, "R8", "busy after load", int'(busy), 1);
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      int    b = k / OS;
      int    c = k % OS;
      string creq;
      bit    indata = (b >= 1) && (b <= nbits(lng));
      if (noisy) creq = "R9";
      else if (indata && b == nbits(lng)) creq = "R5";
      else if (indata) creq = "R4";
      else creq = "R3";
      chk(txd == want_tx(k, lng, word), noisy ? "R9" : "R2", $sformatf("txd tick %0d", k),
          int'(txd), int'(want_tx(k, lng, word)));
      chk(sclk == want_clk(k, lng, pol, pha, lastp), creq, $sformatf("sclk tick %0d", k),
          int'(sclk), int'(want_clk(k, lng, pol, pha, lastp)));
      chk(busy == 1'b1, "R8", "busy during frame", int'(busy), 1);
      // R6: the reply bit is valid only in the capture cycle
      rxd = (indata && c == OS / 2 - 1) ? reply[b-1] : 1'($urandom);
      if (noisy) begin
        // R9: scramble configuration; R8: stray loads must be ignored
        cfg_long = 1'($urandom); cfg_cpol = 1'($urandom);
        cfg_cpha = 1'($urandom); cfg_last_pulse = 1'($urandom);
        if ((k % 37 == 5) && (k < total - 1)) begin
          load_en = 1'b1; load_word = LW'($urandom);
        end
      end
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0; load_en = 1'b0;
      if (k == total - 1) begin
        chk(rx_strobe == 1'b1, "R7", "strobe at end", int'(rx_strobe), 1);
        chk(rx_word == want_reply(lng, reply), "R6", "reply word",
            int'(rx_word), int'(want_reply(lng, reply)));
        chk(busy == 1'b0, "R7", "busy at end", int'(busy), 0);
        cfg_long = lng; cfg_cpol = pol; cfg_cpha = pha; cfg_last_pulse = lastp;
      end else begin
        chk(rx_strobe == 1'b0, "R7", "strobe early", int'(rx_strobe), 0);
      end
      repeat (1 + ($urandom % 2)) @(negedge clk);
    end
    chk(rx_strobe == 1'b0, "R7", "strobe width", int'(rx_strobe), 0);
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "no stray frame", int'(busy), 0);
    chk(txd == 1'b1, "R1", "idle txd", int'(txd), 1);
    chk(sclk == pol, "R3", "idle sclk", int'(sclk), int'(pol));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; os_tick = 1'b0; cfg_long = 1'b0; cfg_cpol = 1'b0;
    cfg_cpha = 1'b0; cfg_last_pulse = 1'b1; load_en = 1'b0; load_word = '0; rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    chk(sclk == 1'b0, "R1", "reset sclk", int'(sclk), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(rx_strobe == 1'b0, "R1", "reset strobe", int'(rx_strobe), 0);
    chk(rx_word == '0, "R1", "reset reply", int'(rx_word), 0);
    cfg_cpol = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == 1'b1, "R1", "idle sclk follows polarity", int'(sclk), 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "idle sclk back to 0", int'(sclk), 0);

    // Directed: every mode combination, with corner data patterns
    for (int m = 0; m < 16; m++) begin
      logic [LW-1:0] w;
      logic [LW-1:0] r;
      case (m % 4)
        0: w = '1;
        1: w = '0;
        2: w = 9'h155;
        default: w = LW'($urandom);
      endcase
      r = (m % 4 == 0) ? '0 : LW'($urandom);
      run_frame(m[0], m[1], m[2], m[3], w, r, 1'b0);
    end
    // Random frames with configuration noise and stray loads
    for (int n = 0; n < 8; n++) begin
      run_frame(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                LW'($urandom), LW'($urandom), 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule